// File: doc/BRIEF.md
# Phase Slew Rate Limiter

This block sits in an all-digital PLL between the phase detector and the loop filter. It receives a signed phase-error sample every system clock and produces a phase-error value for the loop filter. The output follows the input, but its change per cycle is bounded, so that a jump in phase during a reference switchover reaches the loop as a controlled ramp. The output frequency offset stays limited while the loop reacquires lock.

The rate limit is a 16-bit value in nanoseconds of phase per second. A companion scale input converts that rate into phase LSBs per clock, taking the clock rate and the phase LSB weight into account. Each cycle the product of limit and scale is added to a fractional accumulator. The integer carry out of that accumulator is the step allowed in that cycle, so very slow rates still advance the output. A limit of zero, the reset default, turns limiting off and the output copies the input. A status flag shows when the output has been held short of its input.

Top module: `phase_slew_limiter`

## Requirements
- R1: During and after synchronous active-low reset, with no active edge since, `phase_err_out` is 0 and `slewing` is 0.
- R2: When `rate_limit` is 0 at an active edge, `phase_err_out` after that edge equals `phase_err_in` sampled at that edge, and `slewing` is 0.
- R3: At each active edge the product `rate_limit * rate_scale` is added to a FRAC_W-bit fraction that is cleared by reset. The bits of the sum above FRAC_W form the step allowed at that edge, and the low FRAC_W bits are kept.
- R4: When limiting, the output moves toward the input sampled at the edge by exactly the step when the step is smaller than the distance, in the direction of the sign of (input − output).
- R5: The output never passes the input. When the distance is no larger than the step, the output lands exactly on the input.
- R6: `slewing` is 1 after an edge exactly when the output was clamped short of the input sampled at that edge.
- R7: A new `rate_limit` or `rate_scale` value affects the step from the next active edge on. The output keeps its current value, and the fraction is not cleared.
- R8: Phase values are two's complement. The distance is formed one bit wider, so that a move between the most positive and the most negative values goes the long way and does not wrap.
- R9: A product of 1 gives a one-LSB step once every 2^FRAC_W edges, so the slowest rates are not rounded to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_err_in | input | PH_W | Signed phase error from the detector |
| rate_limit | input | LIM_W | Slew limit in ns per second; 0 bypasses |
| rate_scale | input | SCALE_W | Phase LSB fraction per cycle for each ns/s unit |
| phase_err_out | output | PH_W | Signed, rate-limited phase error |
| slewing | output | 1 | Output was clamped short of the input |

## Verification
The bench builds the block with PH_W=16, SCALE_W=8 and FRAC_W=12, keeping LIM_W=16. With these values the per-cycle product ranges from a tiny fraction of an LSB to thousands of LSBs. A 12-bit fraction also lets the one-LSB-per-4096-edges case finish in a few thousand cycles. The 16-bit phase makes it cheap to drive the signed extremes and to cross zero, so random ramps, exact landings, mid-ramp limit changes and bypass all occur within the run.

// File: rtl/psl_pkg.sv
// Package for the phase slew limiter.
// Holds the width helpers that the accumulator and the top both use.
package psl_pkg;

    // Larger of two integers, for derived widths.
    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Width of the step produced by the fractional accumulator.
    function automatic int step_width(input int lim_w, input int scale_w, input int frac_w);
        return max_i(lim_w + scale_w, frac_w) + 1 - frac_w;
    endfunction

    // Direction of a clamped move.
    typedef enum logic {
        MOVE_UP   = 1'b0,
        MOVE_DOWN = 1'b1
    } move_dir_t;

endpackage

// File: rtl/psl_step_accum.sv
// Fractional step accumulator.
// Adds limit*scale to a FRAC_W-bit fraction on every edge. The integer carry
// of that sum is the step allowed at this edge. Assumes that the limit and the
// scale are held static by the caller, or change only between edges.
module psl_step_accum
    import psl_pkg::*;
#(
    parameter int LIM_W   = 16,
    parameter int SCALE_W = 16,
    parameter int FRAC_W  = 32,
    parameter int STEP_W  = step_width(LIM_W, SCALE_W, FRAC_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LIM_W-1:0]   limit,
    input  logic [SCALE_W-1:0] scale,
    output logic [STEP_W-1:0]  step
);
    localparam int INC_W = LIM_W + SCALE_W;
    localparam int ACC_W = max_i(INC_W, FRAC_W) + 1;

    logic [FRAC_W-1:0] frac_q;
    logic [INC_W-1:0]  inc;
    logic [ACC_W-1:0]  sum;

    // Per-edge increment and the sum it forms with the kept fraction.
    always_comb begin
        inc  = INC_W'(limit) * INC_W'(scale);
        sum  = ACC_W'(frac_q) + ACC_W'(inc);
        step = sum[ACC_W-1:FRAC_W];
    end

    // Keep the fractional remainder from edge to edge.
    always_ff @(posedge clk) begin
        if (!rst_n) frac_q <= '0;
        else        frac_q <= sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/psl_clamp.sv
// Clamp stage, combinational.
// Computes the next output. It lands on the target when the target is within
// the step, and otherwise moves the current value by the step toward the target.
// Assumes that both phase values are two's complement of the same width.
module psl_clamp
    import psl_pkg::*;
#(
    parameter int PH_W   = 32,
    parameter int STEP_W = 17
) (
    input  logic [PH_W-1:0]   target,
    input  logic [PH_W-1:0]   current,
    input  logic [STEP_W-1:0] step,
    input  logic              bypass,
    output logic [PH_W-1:0]   next_val,
    output logic              clamped
);
    localparam int DW    = PH_W + 1;
    localparam int CMP_W = max_i(DW, STEP_W);

    logic signed [DW-1:0] diff;
    logic        [DW-1:0] mag;
    logic        [CMP_W-1:0] mag_e, step_e;
    logic        [DW-1:0] cur_e, moved;
    move_dir_t            dir;

    // Distance formed one bit wider so that the extremes cannot wrap.
    always_comb begin
        cur_e = {current[PH_W-1], current};
        diff  = $signed({target[PH_W-1], target}) - $signed(cur_e);
        dir   = diff[DW-1] ? MOVE_DOWN : MOVE_UP;
        mag   = (dir == MOVE_DOWN) ? DW'(-diff) : DW'(diff);
        mag_e  = CMP_W'(mag);
        step_e = CMP_W'(step);
    end

    // Pick the landing point, or a move of one step toward the target.
    always_comb begin
        moved = (dir == MOVE_DOWN) ? cur_e - step_e[DW-1:0] : cur_e + step_e[DW-1:0];
        if (bypass || step_e >= mag_e) begin
            next_val = target;
            clamped  = 1'b0;
        end else begin
            next_val = moved[PH_W-1:0];
            clamped  = 1'b1;
        end
    end
endmodule

// File: rtl/phase_slew_limiter.sv
// Phase slew rate limiter, top.
// Registers a rate-limited copy of the phase error. A zero limit bypasses the
// limiter. Assumes that rate_scale encodes the phase LSB fraction per clock
// for each ns/s of limit, as a FRAC_W-bit fraction.
module phase_slew_limiter
    import psl_pkg::*;
#(
    parameter int PH_W    = 32,
    parameter int LIM_W   = 16,
    parameter int SCALE_W = 16,
    parameter int FRAC_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PH_W-1:0]    phase_err_in,
    input  logic [LIM_W-1:0]   rate_limit,
    input  logic [SCALE_W-1:0] rate_scale,
    output logic [PH_W-1:0]    phase_err_out,
    output logic               slewing
);
    localparam int STEP_W = step_width(LIM_W, SCALE_W, FRAC_W);

    logic [STEP_W-1:0] step;
    logic [PH_W-1:0]   next_val;
    logic              clamped;
    logic              bypass;

    // A zero limit turns limiting off.
    always_comb bypass = (rate_limit == '0);

    psl_step_accum #(
        .LIM_W(LIM_W), .SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)
    ) u_accum (
        .clk(clk), .rst_n(rst_n),
        .limit(rate_limit), .scale(rate_scale),
        .step(step)
    );

    psl_clamp #(.PH_W(PH_W), .STEP_W(STEP_W)) u_clamp (
        .target(phase_err_in), .current(phase_err_out),
        .step(step), .bypass(bypass),
        .next_val(next_val), .clamped(clamped)
    );

    // Output and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_err_out <= '0;
            slewing       <= 1'b0;
        end else begin
            phase_err_out <= next_val;
            slewing       <= clamped;
        end
    end
endmodule

// File: rtl/psl_checker.sv
// Checker for the phase slew limiter, bound to every instance of the top.
module psl_checker #(
    parameter int PH_W  = 32,
    parameter int LIM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PH_W-1:0]  phase_in,
    input logic [LIM_W-1:0] rate_limit,
    input logic [PH_W-1:0]  phase_out,
    input logic             slewing
);
    logic            primed;
    logic [PH_W-1:0] prev_in, prev_out;
    logic            prev_bypass;
    logic            between;

    // Port history from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed      <= 1'b0;
            prev_in     <= '0;
            prev_out    <= '0;
            prev_bypass <= 1'b0;
        end else begin
            primed      <= 1'b1;
            prev_in     <= phase_in;
            prev_out    <= phase_out;
            prev_bypass <= (rate_limit == '0);
        end
    end

    // Output lies between its previous value and the previous input.
    always_comb begin
        if ($signed(prev_in) >= $signed(prev_out))
            between = ($signed(phase_out) >= $signed(prev_out)) && ($signed(phase_out) <= $signed(prev_in));
        else
            between = ($signed(phase_out) <= $signed(prev_out)) && ($signed(phase_out) >= $signed(prev_in));
    end

    assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && prev_bypass) |-> (phase_out == prev_in && !slewing));

    assert_no_overshoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> between);

    assert_flag_means_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && slewing) |-> (phase_out != prev_in));

    assert_flag_clear_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !slewing) |-> (phase_out == prev_in));

    assert_reset_clears_R1: assert property (@(posedge clk)
        (!rst_n) |=> (phase_out == '0 && !slewing));
endmodule

bind phase_slew_limiter psl_checker #(.PH_W(PH_W), .LIM_W(LIM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .phase_in(phase_err_in),
    .rate_limit(rate_limit), .phase_out(phase_err_out), .slewing(slewing)
);

// File: tb/sim_phase_slew_limiter.sv
module sim_phase_slew_limiter;
    localparam int PERIOD  = 10;
    localparam int PH_W    = 16;
    localparam int LIM_W   = 16;
    localparam int SCALE_W = 8;
    localparam int FRAC_W  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PH_W-1:0]    pin = '0;
    logic [LIM_W-1:0]   lim = '0;
    logic [SCALE_W-1:0] scl = '0;
    logic [PH_W-1:0]    pout;
    logic               slew;

    int checks = 0;
    int fails  = 0;
    longint m_frac = 0;
    longint m_out  = 0;
    bit     m_slew = 0;

    always #(PERIOD/2) clk = ~clk;

    phase_slew_limiter #(.PH_W(PH_W), .LIM_W(LIM_W), .SCALE_W(SCALE_W), .FRAC_W(FRAC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .phase_err_in(pin), .rate_limit(lim),
        .rate_scale(scl), .phase_err_out(pout), .slewing(slew)
    );

    function automatic longint sx(input logic [PH_W-1:0] v);
        return longint'($signed(v));
    endfunction

    // Requirement model of one active edge (R2..R5, R8).
    function automatic void model_edge(input longint x, input longint l, input longint s);
        longint sum, step, d, mag;
        sum    = m_frac + l * s;
        step   = sum >>> FRAC_W;
        m_frac = sum & ((64'sd1 <<< FRAC_W) - 1);
        d      = x - m_out;
        mag    = (d < 0) ? -d : d;
        if (l == 0 || mag <= step) begin
            m_out  = x;
            m_slew = 0;
        end else begin
            m_out  = (d < 0) ? m_out - step : m_out + step;
            m_slew = 1;
        end
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, step the model at the rising edge, compare at the next falling edge.
    task automatic cyc(input longint x, input longint l, input longint s, input string tag);
        pin = PH_W'(x); lim = LIM_W'(l); scl = SCALE_W'(s);
        @(posedge clk);
        model_edge(x, l, s);
        @(negedge clk);
        check(tag, sx(pout), m_out);
        check(tag, longint'(slew), longint'(m_slew));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        m_frac = 0; m_out = 0; m_slew = 0;
        check("R1 out", sx(pout), 0);
        check("R1 slewing", longint'(slew), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R2: a zero limit bypasses.
        cyc(1234, 0, 200, "R2 bypass");
        cyc(-30000, 0, 17, "R2 bypass neg");

        // R4/R5: ramp up by a step of 2 per edge (product 8192 / 4096), then land.
        cyc(-29990, 64, 128, "R4 ramp up");
        check("R4 value", sx(pout), -29998);
        for (int i = 0; i < 5; i++) cyc(-29990, 64, 128, "R5 landing");
        check("R5 landed", sx(pout), -29990);
        check("R6 flag low", longint'(slew), 0);

        // R7: change the limit mid-ramp; the output holds its place.
        cyc(1000, 100, 41, "R7 start");
        cyc(1000, 3000, 41, "R7 new limit");
        cyc(1000, 3000, 41, "R7 continue");

        // R8: move from the negative extreme to the positive one the long way.
        cyc(-32768, 0, 0, "R8 setup");
        cyc(32767, 200, 255, "R8 long way");
        check("R8 direction", longint'(sx(pout) > -32768), 1);
        check("R6 flag high", longint'(slew), 1);

        // R9: a product of 1 gives one LSB per 4096 edges.
        do_reset();
        for (int i = 0; i < 8192; i++) cyc(500, 1, 1, "R9 slow");
        check("R9 two steps", sx(pout), 2);

        // R3 and random mix: wide rate range and hold periods.
        for (int i = 0; i < 3000; i++) begin
            longint x, l, s;
            x = longint'($signed(PH_W'($urandom)));
            case ($urandom_range(3, 0))
                0: l = 0;
                1: l = $urandom_range(8, 1);
                2: l = $urandom_range(400, 9);
                default: l = $urandom_range(65535, 0);
            endcase
            s = $urandom_range(255, 0);
            for (int k = 0; k < int'($urandom_range(6, 1)); k++) cyc(x, l, s, "R3 random");
        end

        do_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule